// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the serial core of an SPI master. Software-side logic pushes bytes into a small transmit queue. The engine shifts each byte out on MOSI, most significant bit first. At the same time it assembles one byte from MISO and places it in a receive queue, so every byte sent yields exactly one byte received. SCLK is produced by dividing the block clock by a power of two, and the four active-low slave-select lines come straight from a field of the control word.

A 17-bit control word sets the behaviour. Bit 0 is the master enable. Bit 1 sets the clock idle level and bit 2 sets the sampling phase. Bits [5:3] hold the divisor exponent and bits [13:10] hold the slave-select field. Bit 14 holds the select lines at the field value even between transfers. Bit 15 changes the start rule from automatic to software-triggered, and a rising edge on bit 16 is the trigger. A separate engine-enable input gates everything. The select field is put on the pins exactly as written. One value can therefore be a one-hot-low pattern for four direct slaves, and another can be a binary slave number for an external decoder; all ones means that no slave is addressed.

Top module: `spi_master_core`

## Requirements
- R1: After reset busy is 0, ss_n is 4'hF, rx_empty is 1 and tx_full is 0.
- R2: Each queued byte is sent on MOSI most significant bit first, in queue order. The line is stable at every sampling edge in all four polarity/phase combinations.
- R3: The byte built from the eight MISO samples of a transfer, first sample in bit 7, is pushed into the receive queue and read from rx_data in order.
- R4: Within a byte, SCLK toggles every H block-clock cycles, where H = 1 << baud for baud 1..7 and H = 2 for baud 0.
- R5: While no byte is in flight, SCLK rests at the polarity bit (ctrl bit 1). With phase 0 (ctrl bit 2 = 0) the slave samples on the leading edge; with phase 1 it samples on the trailing edge.
- R6: With bit 14 clear, ss_n equals ctrl[13:10] verbatim (one-hot-low or binary) for the whole of a burst and is 4'hF when the engine is idle.
- R7: With bit 14 set, ss_n equals ctrl[13:10] even while the engine is idle.
- R8: With bit 15 set, queued bytes are not sent until bit 16 goes from 0 to 1. After that trigger the whole queue is sent.
- R9: If ctrl bit 0 or eng_en is 0, no transfer starts. Dropping eng_en mid-byte aborts that byte within one cycle: busy falls, SCLK returns to idle, ss_n becomes 4'hF and no receive byte is pushed.
- R10: A write to a full transmit queue (tx_full = 1, depth 4) is ignored.
- R11: A byte is started only when the receive queue has room. When the queue is full the engine stalls and resumes after a read, and no received byte is lost.
- R12: busy is 1 at every SCLK edge of a burst and falls only after the final byte's last bit has been sampled and pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block (reference) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 17 | Control word: enable, polarity, phase, divisor, select field, select force, manual start mode, start trigger |
| eng_en | input | 1 | Engine gate; 0 halts all activity |
| tx_wr | input | 1 | Push tx_data into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | A byte is in flight |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 4 | Slave-select lines, driven from the control field |
| miso | input | 1 | Serial data in |

## Verification
The bench sweeps every divisor exponent, including the clamped zero, across all four clock modes. It measures each SCLK half period and compares both serial data directions against a bit-level slave model. A divisor decoded off by one, or a sample and shift edge swapped for one phase, shows up as a wrong interval or as bytes rotated by one bit. The bench fills the receive queue and checks that the engine stalls, then resumes one byte per freed slot. A design that ignored the room check would overwrite or drop a byte. Manual start, a write to a full transmit queue, forced select, and an abort mid-byte are each observed at the pins. A premature start, an accepted fifth byte, or a partial byte pushed into the receive queue would each show up there.

// File: rtl/spi_mc_pkg.sv
package spi_mc_pkg;

  localparam int WORD_BITS = 8;
  localparam int EDGES     = 2 * WORD_BITS;
  localparam int BAUD_W    = 3;
  localparam int SS_W      = 4;
  localparam int CTRL_W    = 17;
  localparam int MAX_HALF  = 1 << ((1 << BAUD_W) - 1);
  localparam int TMR_W     = $clog2(MAX_HALF);
  localparam int EC_W      = $clog2(EDGES);

  // Control word field positions.
  localparam int B_MEN    = 0;
  localparam int B_CPOL   = 1;
  localparam int B_CPHA   = 2;
  localparam int B_BAUD   = 3;
  localparam int B_SS     = 10;
  localparam int B_FORCE  = 14;
  localparam int B_MANUAL = 15;
  localparam int B_TRIG   = 16;

  // Block-clock cycles per SCLK half period; exponent 0 is clamped to 1.
  function automatic int unsigned half_cycles(input logic [BAUD_W-1:0] b);
    int unsigned e;
    e = (b == '0) ? 1 : int'(b);
    return 32'd1 << e;
  endfunction

  // Edge index 0 is the leading edge of bit 0; even edges are leading.
  function automatic logic is_sample_edge(input logic [EC_W-1:0] e, input logic cpha);
    return e[0] == cpha;
  endfunction

  function automatic logic is_shift_edge(input logic [EC_W-1:0] e, input logic cpha);
    return !is_sample_edge(e, cpha) && (e != '0) && (e != EC_W'(EDGES - 1));
  endfunction

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         rd,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          wr_ok, rd_ok;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;
  assign dout  = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= bump(wp);
      if (rd_ok) rp <= bump(rp);
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> (cnt == CW'(DEPTH)));

  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd && !wr) |=> empty);

endmodule

// File: rtl/spi_start_ctl.sv
module spi_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic man_mode,
  input  logic trig,
  input  logic tx_nempty,
  input  logic rx_nfull,
  input  logic eng_idle,
  output logic go,
  output logic trig_pulse
);
  logic trig_q;
  logic armed;

  assign trig_pulse = trig && !trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      trig_q <= trig;
      if (!run_en || !man_mode)      armed <= 1'b0;
      else if (trig_pulse)           armed <= 1'b1;
      else if (eng_idle && !tx_nempty) armed <= 1'b0;
    end
  end

  always_comb begin
    go = run_en && tx_nempty && rx_nfull;
    if (man_mode) go = go && (armed || trig_pulse);
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_mc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 go,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic [BAUD_W-1:0]    baud,
  input  logic [WORD_BITS-1:0] tx_byte,
  output logic                 tx_pop,
  output logic                 rx_push,
  output logic [WORD_BITS-1:0] rx_byte,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 busy
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_t;

  st_t                  st;
  logic [TMR_W-1:0]     tmr, reload;
  logic [EC_W-1:0]      ecnt;
  logic [WORD_BITS-1:0] tx_sh, rx_sh, rx_next;
  logic                 sclk_r, mosi_r;

  // Named events for assertions and for reading the sequence.
  logic tmr_zero, edge_now, samp_now, shft_now, last_now, load_now;

  assign tmr_zero = (tmr == '0);
  assign edge_now = run_en && (st == S_RUN) && tmr_zero;
  assign samp_now = edge_now && is_sample_edge(ecnt, cpha);
  assign shft_now = edge_now && is_shift_edge(ecnt, cpha);
  assign last_now = edge_now && (ecnt == EC_W'(EDGES - 1));
  assign load_now = run_en && go && ((st == S_IDLE) || (st == S_TAIL && tmr_zero));
  assign reload   = TMR_W'(half_cycles(baud) - 1);
  assign rx_next  = {rx_sh[WORD_BITS-2:0], miso};

  assign tx_pop  = load_now;
  assign rx_push = last_now;
  assign rx_byte = samp_now ? rx_next : rx_sh;
  assign sclk    = (st == S_IDLE) ? cpol : sclk_r;
  assign mosi    = mosi_r;
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      ecnt   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sclk_r <= 1'b0;
      mosi_r <= 1'b0;
    end else if (!run_en) begin
      st     <= S_IDLE;
      sclk_r <= cpol;
    end else if (load_now) begin
      st     <= S_RUN;
      tmr    <= reload;
      ecnt   <= '0;
      sclk_r <= cpol;
      mosi_r <= tx_byte[WORD_BITS-1];
      tx_sh  <= {tx_byte[WORD_BITS-2:0], 1'b0};
    end else begin
      case (st)
        S_IDLE: sclk_r <= cpol;
        S_RUN: begin
          if (tmr_zero) begin
            sclk_r <= ~sclk_r;
            tmr    <= reload;
            if (samp_now) rx_sh <= rx_next;
            if (shft_now) begin
              mosi_r <= tx_sh[WORD_BITS-1];
              tx_sh  <= {tx_sh[WORD_BITS-2:0], 1'b0};
            end
            if (last_now) st <= S_TAIL;
            else          ecnt <= ecnt + 1'b1;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_TAIL: begin
          if (tmr_zero) st <= S_IDLE;
          else          tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && st == S_RUN && !tmr_zero) |=> $stable(sclk_r));

  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en) |=> (st == S_IDLE));

  p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_now) |=> $stable(mosi_r));

endmodule

// File: rtl/spi_ss_drive.sv
module spi_ss_drive #(
  parameter int SS_W = 4
) (
  input  logic            run_en,
  input  logic            force_sel,
  input  logic            active,
  input  logic [SS_W-1:0] field,
  output logic [SS_W-1:0] ss_n
);
  always_comb begin
    ss_n = '1;
    if (run_en && (force_sel || active)) ss_n = field;
  end
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_mc_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CTRL_W-1:0]    ctrl_word,
  input  logic                 eng_en,
  input  logic                 tx_wr,
  input  logic [WORD_BITS-1:0] tx_data,
  output logic                 tx_full,
  input  logic                 rx_rd,
  output logic [WORD_BITS-1:0] rx_data,
  output logic                 rx_empty,
  output logic                 busy,
  output logic                 sclk,
  output logic                 mosi,
  output logic [SS_W-1:0]      ss_n,
  input  logic                 miso
);
  logic                 run_en, go, trig_pulse;
  logic                 tx_empty, rx_full, tx_pop, rx_push;
  logic [WORD_BITS-1:0] tx_head, rx_in;
  logic [SS_W-1:0]      ss_field;
  logic                 rsvd_unused;

  assign run_en      = eng_en && ctrl_word[B_MEN];
  assign ss_field    = ctrl_word[B_SS +: SS_W];
  assign rsvd_unused = ^ctrl_word[B_SS-1:B_BAUD+BAUD_W];

  spi_fifo #(.W(WORD_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .wr(tx_wr), .din(tx_data), .rd(tx_pop),
    .dout(tx_head), .full(tx_full), .empty(tx_empty));

  spi_fifo #(.W(WORD_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .wr(rx_push), .din(rx_in), .rd(rx_rd),
    .dout(rx_data), .full(rx_full), .empty(rx_empty));

  spi_start_ctl u_start (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .man_mode(ctrl_word[B_MANUAL]), .trig(ctrl_word[B_TRIG]),
    .tx_nempty(!tx_empty), .rx_nfull(!rx_full), .eng_idle(!busy),
    .go(go), .trig_pulse(trig_pulse));

  spi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .go(go),
    .cpol(ctrl_word[B_CPOL]), .cpha(ctrl_word[B_CPHA]),
    .baud(ctrl_word[B_BAUD +: BAUD_W]),
    .tx_byte(tx_head), .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_in),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy));

  spi_ss_drive #(.SS_W(SS_W)) u_ss (
    .run_en(run_en), .force_sel(ctrl_word[B_FORCE]), .active(busy),
    .field(ss_field), .ss_n(ss_n));

  p_rx_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  p_ss_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(ctrl_word) && $stable(eng_en)) |-> $stable(ss_n));

  p_manual_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && ctrl_word[B_MANUAL] && !busy) |-> (trig_pulse || $past(go)));

endmodule

// File: tb/spi_master_core_tb.sv
`timescale 1ns/1ps
module spi_master_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] ctrl = '0;
  logic        eng_en = 1'b0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_full, rx_empty, busy, sclk, mosi;
  logic        rx_rd = 1'b0;
  logic [7:0]  rx_data;
  logic [3:0]  ss_n;
  logic        miso = 1'b0;

  always #10 clk = ~clk;

  spi_master_core u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl), .eng_en(eng_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty),
    .busy(busy), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .miso(miso));

  int nchk = 0;
  int nerr = 0;

  // Slave model state
  logic       mon_on = 1'b0;
  logic       m_cpol = 1'b0, m_cpha = 1'b0;
  logic [3:0] m_field = 4'hF;
  int         m_half = 2;
  int         bitcnt = 0, sidx = 0, nlog = 0, ecount = 0, edges_total = 0;
  int         bad_int = 0, ss_bad = 0, busy_bad = 0;
  logic [7:0] got = '0;
  logic [7:0] mosi_log [16];
  realtime    last_t = 0;

  function automatic logic [7:0] sbyte(input int i);
    return 8'((i * 37 + 5) ^ 8'hA5);
  endfunction
  function automatic logic [7:0] tbyte(input int i, input int seed);
    return 8'(i * 53 + seed * 29 + 8'h3C);
  endfunction
  function automatic int half_of(input int b);
    return (b == 0) ? 2 : (1 << b);
  endfunction
  function automatic logic [16:0] mk(input logic men, cpol, cpha, input int b,
                                      input logic [3:0] f, input logic frc, man, trg);
    logic [16:0] c;
    c = '0;
    c[0] = men; c[1] = cpol; c[2] = cpha; c[5:3] = 3'(b);
    c[13:10] = f; c[14] = frc; c[15] = man; c[16] = trg;
    return c;
  endfunction

  always @(sclk) begin
    if (mon_on && rst_n) begin
      logic lead;
      edges_total++;
      lead = (sclk != m_cpol);
      if (ss_n != m_field) ss_bad++;
      if (!busy) busy_bad++;
      if (ecount != 0 && ($realtime - last_t) != real'(m_half * 20)) bad_int++;
      last_t = $realtime;
      ecount = (ecount + 1) % 16;
      if (lead == !m_cpha) begin
        got = {got[6:0], mosi};
        bitcnt++;
        if (bitcnt == 8) begin
          if (nlog < 16) mosi_log[nlog] = got;
          nlog++;
          bitcnt = 0;
          sidx++;
        end
        miso = sbyte(sidx)[7 - bitcnt];
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic slave_reset(input logic cp, ch, input logic [3:0] f, input int b);
    m_cpol = cp; m_cpha = ch; m_field = f; m_half = half_of(b);
    bitcnt = 0; sidx = 0; nlog = 0; ecount = 0; edges_total = 0;
    bad_int = 0; ss_bad = 0; busy_bad = 0;
    miso = sbyte(0)[7];
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] d);
    @(negedge clk); d = rx_data; rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 40000; k++) begin
      @(negedge clk);
      if (!busy && nlog >= n) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic burst(input int b, input logic cp, ch, input logic [3:0] f, input int n, input int seed);
    logic [7:0] d;
    mon_on = 1'b0;
    @(negedge clk); ctrl = mk(1'b1, cp, ch, b, f, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(sclk == cp, "R5 idle level", sclk, cp);
    chk(ss_n == 4'hF, "R6 idle ss", ss_n, 4'hF);
    slave_reset(cp, ch, f, b);
    mon_on = 1'b1;
    for (int i = 0; i < n; i++) push_tx(tbyte(i, seed));
    wait_done(n);
    chk(nlog == n, "R2 byte count", nlog, n);
    for (int i = 0; i < n; i++) chk(mosi_log[i] == tbyte(i, seed), "R2 mosi byte", mosi_log[i], tbyte(i, seed));
    chk(bad_int == 0, "R4 half period", bad_int, 0);
    chk(ss_bad == 0, "R6 ss during burst", ss_bad, 0);
    chk(busy_bad == 0 && busy == 1'b0, "R12 busy span", busy_bad, 0);
    chk(sclk == cp, "R5 rest after burst", sclk, cp);
    chk(ss_n == 4'hF, "R6 ss after burst", ss_n, 4'hF);
    mon_on = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(rx_empty == 1'b0, "R12 rx present at busy fall", rx_empty, 0);
      pop_rx(d);
      chk(d == sbyte(i), "R3 rx byte", d, sbyte(i));
    end
    chk(rx_empty == 1'b1, "R3 rx drained", rx_empty, 1);
  endtask

  initial begin
    #3_000_000;
    nerr++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(ss_n == 4'hF, "R1 ss reset", ss_n, 4'hF);
    chk(rx_empty == 1'b1, "R1 rx empty reset", rx_empty, 1);
    chk(tx_full == 1'b0, "R1 tx full reset", tx_full, 0);
    rst_n = 1'b1;
    eng_en = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep divisor exponents and clock modes; alternate one-hot and binary select fields.
    for (int b = 0; b < 8; b++) begin
      logic [3:0] f;
      f = b[0] ? 4'(b % 4) : ~(4'b1 << (b % 4));
      burst(b, b[1], b[0], f, (b < 3) ? 4 : 2, b);
    end
    for (int m = 0; m < 4; m++) burst(1, m[1], m[0], ~(4'b1 << m), 3, 10 + m);

    // R7: forced select while idle
    @(negedge clk); ctrl = mk(1'b1, 1'b0, 1'b0, 1, 4'b1101, 1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk(ss_n == 4'b1101 && !busy, "R7 forced ss idle", ss_n, 4'b1101);
    eng_en = 1'b0;
    @(negedge clk);
    chk(ss_n == 4'hF, "R9 ss when gated off", ss_n, 4'hF);
    eng_en = 1'b1;

    // R8: manual start
    @(negedge clk); ctrl = mk(1'b1, 1'b0, 1'b1, 1, 4'b1110, 1'b0, 1'b1, 1'b0);
    slave_reset(1'b0, 1'b1, 4'b1110, 1); mon_on = 1'b1;
    push_tx(tbyte(0, 7)); push_tx(tbyte(1, 7));
    repeat (60) @(negedge clk);
    chk(busy == 1'b0 && edges_total == 0, "R8 held without trigger", edges_total, 0);
    ctrl[16] = 1'b1;
    wait_done(2);
    ctrl[16] = 1'b0;
    chk(nlog == 2 && mosi_log[0] == tbyte(0, 7) && mosi_log[1] == tbyte(1, 7), "R8 sent after trigger", nlog, 2);
    pop_rx(d); pop_rx(d);
    mon_on = 1'b0;

    // R10: full transmit queue ignores fifth write
    slave_reset(1'b0, 1'b1, 4'b1110, 1); mon_on = 1'b1;
    for (int i = 0; i < 5; i++) begin
      push_tx(tbyte(i, 3));
      if (i == 3) chk(tx_full == 1'b1, "R10 full after depth", tx_full, 1);
    end
    @(negedge clk); ctrl[16] = 1'b1;
    wait_done(4);
    ctrl[16] = 1'b0;
    repeat (200) @(negedge clk);
    chk(nlog == 4, "R10 fifth write ignored", nlog, 4);
    for (int i = 0; i < 4; i++) chk(mosi_log[i] == tbyte(i, 3), "R10 order kept", mosi_log[i], tbyte(i, 3));
    for (int i = 0; i < 4; i++) pop_rx(d);
    mon_on = 1'b0;

    // R9: master enable bit clear blocks start, then set lets it go
    @(negedge clk); ctrl = mk(1'b0, 1'b1, 1'b0, 1, 4'b0111, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    slave_reset(1'b1, 1'b0, 4'b0111, 1); mon_on = 1'b1;
    push_tx(tbyte(0, 9));
    repeat (60) @(negedge clk);
    chk(busy == 1'b0 && edges_total == 0, "R9 no start without master enable", edges_total, 0);
    ctrl[0] = 1'b1;
    wait_done(1);
    chk(nlog == 1 && mosi_log[0] == tbyte(0, 9), "R9 starts once enabled", mosi_log[0], tbyte(0, 9));
    pop_rx(d);
    chk(d == sbyte(0), "R3 rx after enable", d, sbyte(0));
    mon_on = 1'b0;

    // R9: abort mid-byte
    @(negedge clk); ctrl = mk(1'b1, 1'b0, 1'b0, 3, 4'b1011, 1'b0, 1'b0, 1'b0);
    push_tx(8'h5A);
    repeat (40) @(negedge clk);
    chk(busy == 1'b1, "R9 byte in flight", busy, 1);
    eng_en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && sclk == 1'b0 && ss_n == 4'hF, "R9 abort idle", {busy, sclk, ss_n}, 6'h0F);
    eng_en = 1'b1;
    repeat (300) @(negedge clk);
    chk(rx_empty == 1'b1 && busy == 1'b0, "R9 no partial rx byte", rx_empty, 1);

    // R11: receive queue full stalls the engine
    @(negedge clk); ctrl = mk(1'b1, 1'b1, 1'b1, 1, 4'b0010, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    slave_reset(1'b1, 1'b1, 4'b0010, 1); mon_on = 1'b1;
    for (int i = 0; i < 4; i++) push_tx(tbyte(i, 5));
    wait_done(4);
    push_tx(tbyte(4, 5)); push_tx(tbyte(5, 5));
    repeat (200) @(negedge clk);
    chk(nlog == 4 && busy == 1'b0, "R11 stall on full rx", nlog, 4);
    pop_rx(d);
    chk(d == sbyte(0), "R11 first rx", d, sbyte(0));
    wait_done(5);
    repeat (200) @(negedge clk);
    chk(nlog == 5, "R11 one byte per freed slot", nlog, 5);
    for (int i = 1; i < 5; i++) begin
      pop_rx(d);
      chk(d == sbyte(i), "R11 rx order", d, sbyte(i));
    end
    wait_done(6);
    chk(nlog == 6 && mosi_log[5] == tbyte(5, 5), "R11 resumed last byte", nlog, 6);
    pop_rx(d);
    chk(d == sbyte(5), "R11 last rx", d, sbyte(5));
    mon_on = 1'b0;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule